// File: doc/BRIEF.md
# Oscilloscope Host Command Controller

This block is the control state machine of a sampling instrument that is driven by a host computer over a byte link. A receiver upstream delivers whole command frames. Each frame is a code byte plus two payload bytes, marked by a one-cycle valid strobe. The controller classifies the code and updates the acquisition settings: trigger, channel, time base and sampling mode. It then asks a frame transmitter downstream for an acknowledge, a negative acknowledge, a version reply or a sample-data packet. Each request is held until the transmitter reports it done.

Right after reset, the controller swallows a short dummy exchange, so that link noise during power-up cannot start a reply. This happens once only. Sample data is streamed packet by packet, with buffer addresses counting up from zero. Between packets the controller waits for a host-received code. Any other command arriving during that wait ends the stream and is handled as a fresh command.

Top module: `scope_cmd_ctrl`

## Requirements
- R1: After reset, the first DUMMY_LEN (default 2) receive strobes are consumed whatever their bytes hold. They raise no reply and change no setting. Later strobes are treated as commands, and the dummy phase never returns without a new reset.
- R2: Code 0x01 yields reply kind 1 with info HW_VER. Code 0x02 yields kind 2 with info SW_VER. An accepted setting command yields kind 3 (acknowledge) with info 0x00. After each of these replies the controller is idle again.
- R3: A code outside the set {0x01, 0x02, 0x10, 0x11, 0x12, 0x13, 0x20} yields reply kind 4 (negative acknowledge) with info 0x01 (unknown command). This includes 0x30 when it arrives outside a stream.
- R4: After a negative acknowledge, the controller waits. It ignores every strobe whose code is outside the command set, 0x30 included, and it handles the next strobe whose code is in the set.
- R5: Code 0x10 sets the trigger registers. The channel comes from byte0 bits [1:0]. The type comes from byte0 bits [3:2], with 0 for rising, 1 for falling and 2 for either edge. The level comes from byte1. A type of 3 yields kind 4 with info 0x02 (invalid parameter) and leaves all trigger registers unchanged.
- R6: Code 0x11 stores the 16-bit channel configuration {byte1, byte0} and acknowledges.
- R7: Code 0x12 stores the time base as a little-endian cycle count {byte1, byte0} and acknowledges.
- R8: Code 0x13 sets the equivalent-time mode from byte0 bit 0 (0 for real time, 1 for equivalent time). If any of byte0 bits [7:1] is set, the controller yields kind 4 with info 0x02 and leaves the mode unchanged.
- R9: A reply request stays asserted, with kind and info stable, until tx_done_i is seen high. It is low in the cycle after that.
- R10: Code 0x20 streams PKT_COUNT (default 4) packets of kind 5. Each packet has smp_rd_o high and smp_addr_o equal to the packet index, counting from 0. Between packets no request is raised until a code 0x30 arrives. After the last packet the controller is idle.
- R11: A strobe with a code other than 0x30, received while waiting between packets, ends the stream and is handled as a command.
- R12: Strobes that arrive while a reply request is pending are ignored.
- R13: After reset the trigger channel, type and level, the channel configuration and the mode are 0, and the time base is TB_INIT (default 1). Settings change only through an accepted command, and the new value is visible when its acknowledge is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | One-cycle strobe: a received frame is present |
| rx_code_i | input | 8 | Command code of the received frame |
| rx_pay0_i | input | 8 | First payload byte |
| rx_pay1_i | input | 8 | Second payload byte |
| tx_req_o | output | 1 | Reply request to the frame transmitter |
| tx_kind_o | output | 3 | Reply kind: 1 hw version, 2 sw version, 3 ack, 4 nack, 5 sample packet |
| tx_info_o | output | 8 | Version value or error code for the reply |
| tx_done_i | input | 1 | Transmitter has finished the requested reply |
| smp_rd_o | output | 1 | Sample buffer read enable while a packet is requested |
| smp_addr_o | output | max(1, clog2(PKT_COUNT)) | Sample buffer packet address |
| trig_chan_o | output | 2 | Active trigger channel |
| trig_type_o | output | 2 | Trigger edge type |
| trig_level_o | output | 8 | Trigger level |
| chan_cfg_o | output | 16 | Channel configuration word |
| tb_cycles_o | output | TB_W | Clock cycles between stored samples |
| ets_mode_o | output | 1 | Equivalent-time sampling selected |

## Verification
The bench first feeds a valid-looking command during the dummy phase. A design that skipped or shortened that phase would answer it or load the trigger. It sends rejected trigger-type and mode payloads between accepted ones and then reads the settings back, so a design that wrote before validating would show corrupted registers. After a negative acknowledge it offers unknown codes and a stray 0x30, which a design without a real wait state would answer. During a stream it checks the packet addresses, the silence between packets, the return to idle after the last packet, and the abort by a version request, which a design that kept streaming would answer with a sample packet instead.

// File: rtl/scope_ctl_pkg.sv
package scope_ctl_pkg;

   typedef enum logic [3:0] {
      ST_PWRUP, ST_IDLE, ST_CHECK, ST_SET_TRIG, ST_SET_CHAN, ST_SET_TB,
      ST_SET_MODE, ST_RPL_HW, ST_RPL_SW, ST_ACK, ST_NACK, ST_WAIT_NACK,
      ST_SEND_SD, ST_WAIT_HOST
   } ctl_state_e;

   typedef enum logic [2:0] {
      CMD_HWV, CMD_SWV, CMD_TRIG, CMD_CHAN, CMD_TB, CMD_MODE, CMD_SD, CMD_BAD
   } cmd_class_e;

   localparam logic [7:0] OP_HWV      = 8'h01;
   localparam logic [7:0] OP_SWV      = 8'h02;
   localparam logic [7:0] OP_TRIG     = 8'h10;
   localparam logic [7:0] OP_CHAN     = 8'h11;
   localparam logic [7:0] OP_TB       = 8'h12;
   localparam logic [7:0] OP_MODE     = 8'h13;
   localparam logic [7:0] OP_SD       = 8'h20;
   localparam logic [7:0] OP_HOST_ACK = 8'h30;

   localparam logic [2:0] RPL_NONE   = 3'd0;
   localparam logic [2:0] RPL_HW     = 3'd1;
   localparam logic [2:0] RPL_SW     = 3'd2;
   localparam logic [2:0] RPL_ACK    = 3'd3;
   localparam logic [2:0] RPL_NACK   = 3'd4;
   localparam logic [2:0] RPL_SAMPLE = 3'd5;

   localparam logic [7:0] ERR_NONE    = 8'h00;
   localparam logic [7:0] ERR_UNKNOWN = 8'h01;
   localparam logic [7:0] ERR_PARAM   = 8'h02;

endpackage

// File: rtl/scope_cmd_decode.sv
module scope_cmd_decode
   import scope_ctl_pkg::*;
(
   input  logic [7:0] code_i,
   input  logic [7:0] pay0_i,
   output cmd_class_e cls_o,
   output logic       param_ok_o
);

   always_comb begin
      unique case (code_i)
         OP_HWV:  cls_o = CMD_HWV;
         OP_SWV:  cls_o = CMD_SWV;
         OP_TRIG: cls_o = CMD_TRIG;
         OP_CHAN: cls_o = CMD_CHAN;
         OP_TB:   cls_o = CMD_TB;
         OP_MODE: cls_o = CMD_MODE;
         OP_SD:   cls_o = CMD_SD;
         default: cls_o = CMD_BAD;
      endcase
   end

   // trigger type 3 is not an edge; mode accepts only bit 0
   always_comb begin
      unique case (cls_o)
         CMD_TRIG: param_ok_o = (pay0_i[3:2] != 2'b11);
         CMD_MODE: param_ok_o = (pay0_i[7:1] == 7'd0);
         default:  param_ok_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/scope_cfg_regs.sv
module scope_cfg_regs #(
   parameter int unsigned TB_W    = 16,
   parameter int unsigned TB_INIT = 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_trig_i,
   input  logic            wr_chan_i,
   input  logic            wr_tb_i,
   input  logic            wr_mode_i,
   input  logic [7:0]      pay0_i,
   input  logic [7:0]      pay1_i,
   output logic [1:0]      trig_chan_o,
   output logic [1:0]      trig_type_o,
   output logic [7:0]      trig_level_o,
   output logic [15:0]     chan_cfg_o,
   output logic [TB_W-1:0] tb_cycles_o,
   output logic            ets_mode_o
);

   logic [15:0] tb_raw;
   assign tb_raw = {pay1_i, pay0_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         trig_chan_o  <= '0;
         trig_type_o  <= '0;
         trig_level_o <= '0;
         chan_cfg_o   <= '0;
         tb_cycles_o  <= TB_W'(TB_INIT);
         ets_mode_o   <= 1'b0;
      end else begin
         if (wr_trig_i) begin
            trig_chan_o  <= pay0_i[1:0];
            trig_type_o  <= pay0_i[3:2];
            trig_level_o <= pay1_i;
         end
         if (wr_chan_i) chan_cfg_o  <= tb_raw;
         if (wr_tb_i)   tb_cycles_o <= tb_raw[TB_W-1:0];
         if (wr_mode_i) ets_mode_o  <= pay0_i[0];
      end
   end

endmodule

// File: rtl/scope_pkt_ctr.sv
module scope_pkt_ctr #(
   parameter int unsigned COUNT = 4,
   localparam int unsigned AW   = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [AW-1:0] idx_o,
   output logic          last_o
);

   if (COUNT == 1) begin : g_single
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni ^ clr_i ^ inc_i;
      assign idx_o  = '0;
      assign last_o = 1'b1;
   end else begin : g_count
      logic [AW-1:0] cnt_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni || clr_i) cnt_q <= '0;
         else if (inc_i)       cnt_q <= cnt_q + 1'b1;
      end
      assign idx_o  = cnt_q;
      assign last_o = (cnt_q == AW'(COUNT - 1));
   end

endmodule

// File: rtl/scope_cmd_ctrl.sv
module scope_cmd_ctrl
   import scope_ctl_pkg::*;
#(
   parameter logic [7:0]  HW_VER    = 8'hA1,
   parameter logic [7:0]  SW_VER    = 8'h07,
   parameter int unsigned PKT_COUNT = 4,
   parameter int unsigned DUMMY_LEN = 2,
   parameter int unsigned TB_W      = 16,
   parameter int unsigned TB_INIT   = 1,
   localparam int unsigned SA_W     = (PKT_COUNT > 1) ? $clog2(PKT_COUNT) : 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            rx_valid_i,
   input  logic [7:0]      rx_code_i,
   input  logic [7:0]      rx_pay0_i,
   input  logic [7:0]      rx_pay1_i,
   output logic            tx_req_o,
   output logic [2:0]      tx_kind_o,
   output logic [7:0]      tx_info_o,
   input  logic            tx_done_i,
   output logic            smp_rd_o,
   output logic [SA_W-1:0] smp_addr_o,
   output logic [1:0]      trig_chan_o,
   output logic [1:0]      trig_type_o,
   output logic [7:0]      trig_level_o,
   output logic [15:0]     chan_cfg_o,
   output logic [TB_W-1:0] tb_cycles_o,
   output logic            ets_mode_o
);

   localparam int unsigned DC_W = $clog2(DUMMY_LEN + 1);

   if (PKT_COUNT < 1) begin : g_bad_pkt
      $error("PKT_COUNT must be at least 1");
   end
   if (DUMMY_LEN < 1) begin : g_bad_dummy
      $error("DUMMY_LEN must be at least 1");
   end
   if (TB_W < 2 || TB_W > 16) begin : g_bad_tb
      $error("TB_W must lie in 2..16");
   end

   ctl_state_e       state_q, state_d;
   logic [7:0]       code_q, p0_q, p1_q, err_q, err_val;
   logic [DC_W-1:0]  dcnt_q;
   logic             latch, dcnt_inc, set_err, clr_err;
   logic             wr_trig, wr_chan, wr_tb, wr_mode;
   logic             pkt_clr, pkt_inc, pkt_last;
   logic [7:0]       dec_code;
   cmd_class_e       dec_cls;
   logic             dec_ok;

   // the wait-after-nack state classifies the live code, all others the held one
   assign dec_code = (state_q == ST_WAIT_NACK) ? rx_code_i : code_q;

   scope_cmd_decode u_dec (
      .code_i     (dec_code),
      .pay0_i     (p0_q),
      .cls_o      (dec_cls),
      .param_ok_o (dec_ok)
   );

   scope_cfg_regs #(.TB_W(TB_W), .TB_INIT(TB_INIT)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_trig_i    (wr_trig),
      .wr_chan_i    (wr_chan),
      .wr_tb_i      (wr_tb),
      .wr_mode_i    (wr_mode),
      .pay0_i       (p0_q),
      .pay1_i       (p1_q),
      .trig_chan_o  (trig_chan_o),
      .trig_type_o  (trig_type_o),
      .trig_level_o (trig_level_o),
      .chan_cfg_o   (chan_cfg_o),
      .tb_cycles_o  (tb_cycles_o),
      .ets_mode_o   (ets_mode_o)
   );

   scope_pkt_ctr #(.COUNT(PKT_COUNT)) u_pkt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (pkt_clr),
      .inc_i  (pkt_inc),
      .idx_o  (smp_addr_o),
      .last_o (pkt_last)
   );

   always_comb begin
      state_d  = state_q;
      latch    = 1'b0;
      dcnt_inc = 1'b0;
      set_err  = 1'b0;
      clr_err  = 1'b0;
      err_val  = ERR_NONE;
      wr_trig  = 1'b0;
      wr_chan  = 1'b0;
      wr_tb    = 1'b0;
      wr_mode  = 1'b0;
      pkt_clr  = 1'b0;
      pkt_inc  = 1'b0;
      unique case (state_q)
         ST_PWRUP: if (rx_valid_i) begin
            if (dcnt_q == DC_W'(DUMMY_LEN - 1)) state_d = ST_IDLE;
            else                                dcnt_inc = 1'b1;
         end
         ST_IDLE: if (rx_valid_i) begin
            latch   = 1'b1;
            state_d = ST_CHECK;
         end
         ST_CHECK: begin
            unique case (dec_cls)
               CMD_HWV:  state_d = ST_RPL_HW;
               CMD_SWV:  state_d = ST_RPL_SW;
               CMD_TRIG: state_d = ST_SET_TRIG;
               CMD_CHAN: state_d = ST_SET_CHAN;
               CMD_TB:   state_d = ST_SET_TB;
               CMD_MODE: state_d = ST_SET_MODE;
               CMD_SD: begin
                  pkt_clr = 1'b1;
                  state_d = ST_SEND_SD;
               end
               default: begin
                  set_err = 1'b1;
                  err_val = ERR_UNKNOWN;
                  state_d = ST_NACK;
               end
            endcase
         end
         ST_SET_TRIG, ST_SET_MODE: begin
            if (dec_ok) begin
               wr_trig = (state_q == ST_SET_TRIG);
               wr_mode = (state_q == ST_SET_MODE);
               state_d = ST_ACK;
            end else begin
               set_err = 1'b1;
               err_val = ERR_PARAM;
               state_d = ST_NACK;
            end
         end
         ST_SET_CHAN: begin
            wr_chan = 1'b1;
            state_d = ST_ACK;
         end
         ST_SET_TB: begin
            wr_tb   = 1'b1;
            state_d = ST_ACK;
         end
         ST_RPL_HW, ST_RPL_SW, ST_ACK: if (tx_done_i) state_d = ST_IDLE;
         ST_NACK: if (tx_done_i) begin
            clr_err = 1'b1;
            pkt_clr = 1'b1;
            state_d = ST_WAIT_NACK;
         end
         ST_WAIT_NACK: if (rx_valid_i && dec_cls != CMD_BAD) begin
            latch   = 1'b1;
            state_d = ST_CHECK;
         end
         ST_SEND_SD: if (tx_done_i) begin
            if (pkt_last) state_d = ST_IDLE;
            else begin
               pkt_inc = 1'b1;
               state_d = ST_WAIT_HOST;
            end
         end
         ST_WAIT_HOST: if (rx_valid_i) begin
            if (rx_code_i == OP_HOST_ACK) state_d = ST_SEND_SD;
            else begin
               latch   = 1'b1;
               state_d = ST_CHECK;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_PWRUP;
         dcnt_q  <= '0;
         code_q  <= '0;
         p0_q    <= '0;
         p1_q    <= '0;
         err_q   <= ERR_NONE;
      end else begin
         state_q <= state_d;
         if (dcnt_inc) dcnt_q <= dcnt_q + 1'b1;
         if (latch) begin
            code_q <= rx_code_i;
            p0_q   <= rx_pay0_i;
            p1_q   <= rx_pay1_i;
         end
         if (set_err)      err_q <= err_val;
         else if (clr_err) err_q <= ERR_NONE;
      end
   end

   always_comb begin
      tx_req_o  = 1'b1;
      tx_info_o = 8'h00;
      smp_rd_o  = 1'b0;
      unique case (state_q)
         ST_RPL_HW: begin tx_kind_o = RPL_HW; tx_info_o = HW_VER; end
         ST_RPL_SW: begin tx_kind_o = RPL_SW; tx_info_o = SW_VER; end
         ST_ACK:    tx_kind_o = RPL_ACK;
         ST_NACK:   begin tx_kind_o = RPL_NACK; tx_info_o = err_q; end
         ST_SEND_SD: begin tx_kind_o = RPL_SAMPLE; smp_rd_o = 1'b1; end
         default:   begin tx_kind_o = RPL_NONE; tx_req_o = 1'b0; end
      endcase
   end

endmodule

// File: rtl/scope_cmd_ctrl_chk.sv
module scope_cmd_ctrl_chk #(
   parameter int unsigned PKT_COUNT = 4,
   parameter int unsigned TB_W      = 16,
   localparam int unsigned SA_W     = (PKT_COUNT > 1) ? $clog2(PKT_COUNT) : 1
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            tx_req_o,
   input logic            tx_done_i,
   input logic [2:0]      tx_kind_o,
   input logic [7:0]      tx_info_o,
   input logic            smp_rd_o,
   input logic [SA_W-1:0] smp_addr_o,
   input logic [1:0]      trig_type_o,
   input logic [7:0]      trig_level_o,
   input logic [TB_W-1:0] tb_cycles_o,
   input logic            ets_mode_o
);

   p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_req_o && !tx_done_i |=> tx_req_o && $stable(tx_kind_o) && $stable(tx_info_o)
                                 && $stable(smp_addr_o));

   p_req_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_req_o && tx_done_i |=> !tx_req_o);

   p_nack_has_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_req_o && tx_kind_o == 3'd4 |-> tx_info_o != 8'h00);

   p_trig_type_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_type_o != 2'd3);

   p_trig_with_ack_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(trig_level_o) |-> tx_req_o && tx_kind_o == 3'd3);

   p_tb_with_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(tb_cycles_o) |-> tx_req_o && tx_kind_o == 3'd3);

   p_mode_with_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ets_mode_o) |-> tx_req_o && tx_kind_o == 3'd3);

   p_addr_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_rd_o |-> smp_addr_o <= SA_W'(PKT_COUNT - 1));

endmodule

bind scope_cmd_ctrl scope_cmd_ctrl_chk #(.PKT_COUNT(PKT_COUNT), .TB_W(TB_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .tx_req_o     (tx_req_o),
   .tx_done_i    (tx_done_i),
   .tx_kind_o    (tx_kind_o),
   .tx_info_o    (tx_info_o),
   .smp_rd_o     (smp_rd_o),
   .smp_addr_o   (smp_addr_o),
   .trig_type_o  (trig_type_o),
   .trig_level_o (trig_level_o),
   .tb_cycles_o  (tb_cycles_o),
   .ets_mode_o   (ets_mode_o)
);

// File: tb/scope_cmd_ctrl_tb.sv
module scope_cmd_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 11;

   // {code, byte0, byte1, expected kind, expected info}
   localparam logic [34:0] VECS [0:NVEC-1] = '{
      {8'h01, 8'h00, 8'h00, 3'd1, 8'hA1},   // R2 hw version
      {8'h02, 8'h00, 8'h00, 3'd2, 8'h07},   // R2 sw version
      {8'h10, 8'h06, 8'h5A, 3'd3, 8'h00},   // R5 chan 2, falling, level 5A
      {8'h55, 8'h00, 8'h00, 3'd4, 8'h01},   // R3 unknown
      {8'h13, 8'h01, 8'h00, 3'd3, 8'h00},   // R8 equivalent time
      {8'h13, 8'h03, 8'h00, 3'd4, 8'h02},   // R8 bad mode bits
      {8'h12, 8'h34, 8'h12, 3'd3, 8'h00},   // R7 time base 0x1234
      {8'h10, 8'h0C, 8'h99, 3'd4, 8'h02},   // R5 type 3 rejected
      {8'h11, 8'hCD, 8'hAB, 3'd3, 8'h00},   // R6 channel config
      {8'h30, 8'h00, 8'h00, 3'd4, 8'h01},   // R3 host ack outside stream
      {8'h02, 8'h00, 8'h00, 3'd2, 8'h07}    // R2 after nack wait
   };

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        rx_valid_i = 1'b0;
   logic [7:0]  rx_code_i = '0, rx_pay0_i = '0, rx_pay1_i = '0;
   logic        tx_done_i = 1'b0;
   logic        tx_req_o, smp_rd_o, ets_mode_o;
   logic [2:0]  tx_kind_o;
   logic [7:0]  tx_info_o, trig_level_o;
   logic [1:0]  smp_addr_o, trig_chan_o, trig_type_o;
   logic [15:0] chan_cfg_o, tb_cycles_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scope_cmd_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_code_i(rx_code_i),
      .rx_pay0_i(rx_pay0_i), .rx_pay1_i(rx_pay1_i), .tx_req_o(tx_req_o),
      .tx_kind_o(tx_kind_o), .tx_info_o(tx_info_o), .tx_done_i(tx_done_i),
      .smp_rd_o(smp_rd_o), .smp_addr_o(smp_addr_o), .trig_chan_o(trig_chan_o),
      .trig_type_o(trig_type_o), .trig_level_o(trig_level_o), .chan_cfg_o(chan_cfg_o),
      .tb_cycles_o(tb_cycles_o), .ets_mode_o(ets_mode_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c, input logic [7:0] b0, input logic [7:0] b1);
      rx_code_i  = c;
      rx_pay0_i  = b0;
      rx_pay1_i  = b1;
      rx_valid_i = 1'b1;
      @(negedge clk);
      rx_valid_i = 1'b0;
   endtask

   task automatic wait_req();
      for (int w = 0; w < 16 && !tx_req_o; w++) @(negedge clk);
   endtask

   task automatic pulse_done();
      tx_done_i = 1'b1;
      @(negedge clk);
      tx_done_i = 1'b0;
   endtask

   task automatic reply(input logic [2:0] k, input logic [7:0] inf, input string tag);
      wait_req();
      chk(tx_req_o == 1'b1, tag, "request", 32'(tx_req_o), 32'd1);
      chk(tx_kind_o == k, tag, "kind", 32'(tx_kind_o), 32'(k));
      chk(tx_info_o == inf, tag, "info", 32'(tx_info_o), 32'(inf));
      pulse_done();
   endtask

   task automatic quiet(input int n, input string tag);
      bit ok = 1'b1;
      repeat (n) begin
         @(negedge clk);
         if (tx_req_o) ok = 1'b0;
      end
      chk(ok, tag, "no request expected", 32'(tx_req_o), 32'd0);
   endtask

   function automatic string tag_of(input logic [7:0] c);
      case (c)
         8'h01, 8'h02: return "R2";
         8'h10: return "R5";
         8'h11: return "R6";
         8'h12: return "R7";
         8'h13: return "R8";
         default: return "R3";
      endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      // R13 reset values
      chk(tx_req_o == 1'b0, "R13", "reset request", 32'(tx_req_o), 32'd0);
      chk(tb_cycles_o == 16'd1, "R13", "reset time base", 32'(tb_cycles_o), 32'd1);
      chk({trig_chan_o, trig_type_o, trig_level_o, chan_cfg_o, ets_mode_o} == '0,
          "R13", "reset settings", 32'(trig_level_o), 32'd0);

      // R1 dummy exchange: command-looking bytes are swallowed
      send(8'h01, 8'h00, 8'h00);
      quiet(6, "R1");
      send(8'h10, 8'h05, 8'h77);
      quiet(6, "R1");
      chk(trig_level_o == 8'h00 && trig_chan_o == 2'd0, "R1", "dummy left trigger",
          32'(trig_level_o), 32'd0);

      // table walk: R2 R3 R5 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         send(VECS[i][34:27], VECS[i][26:19], VECS[i][18:11]);
         reply(VECS[i][10:8], VECS[i][7:0], tag_of(VECS[i][34:27]));
      end
      chk(trig_chan_o == 2'd2, "R5", "trigger channel", 32'(trig_chan_o), 32'd2);
      chk(trig_type_o == 2'd1, "R5", "trigger type kept", 32'(trig_type_o), 32'd1);
      chk(trig_level_o == 8'h5A, "R5", "trigger level kept", 32'(trig_level_o), 32'h5A);
      chk(chan_cfg_o == 16'hABCD, "R6", "channel config", 32'(chan_cfg_o), 32'hABCD);
      chk(tb_cycles_o == 16'h1234, "R7", "time base", 32'(tb_cycles_o), 32'h1234);
      chk(ets_mode_o == 1'b1, "R8", "mode kept", 32'(ets_mode_o), 32'd1);

      // R4 wait after nack ignores unknown codes and host ack
      send(8'h77, 8'h00, 8'h00);
      reply(3'd4, 8'h01, "R4");
      send(8'h66, 8'h00, 8'h00);
      quiet(6, "R4");
      send(8'h30, 8'h00, 8'h00);
      quiet(6, "R4");
      send(8'h01, 8'h00, 8'h00);
      reply(3'd1, 8'hA1, "R4");

      // R9 held request, R12 strobe during pending reply ignored
      send(8'h02, 8'h00, 8'h00);
      wait_req();
      send(8'h55, 8'h00, 8'h00);
      begin
         bit held = 1'b1;
         repeat (5) begin
            if (!(tx_req_o && tx_kind_o == 3'd2 && tx_info_o == 8'h07)) held = 1'b0;
            @(negedge clk);
         end
         chk(held, "R9", "request held without done", 32'(tx_kind_o), 32'd2);
      end
      pulse_done();
      chk(tx_req_o == 1'b0, "R9", "request dropped after done", 32'(tx_req_o), 32'd0);
      quiet(6, "R12");

      // R10 full stream of four packets
      send(8'h20, 8'h00, 8'h00);
      for (int p = 0; p < 4; p++) begin
         wait_req();
         chk(tx_kind_o == 3'd5 && smp_rd_o, "R10", "sample packet", 32'(tx_kind_o), 32'd5);
         chk(smp_addr_o == 2'(p), "R10", "packet address", 32'(smp_addr_o), 32'(p));
         pulse_done();
         if (p < 3) begin
            quiet(5, "R10");
            send(8'h30, 8'h00, 8'h00);
         end
      end
      send(8'h30, 8'h00, 8'h00);
      reply(3'd4, 8'h01, "R10");
      send(8'h01, 8'h00, 8'h00);
      reply(3'd1, 8'hA1, "R10");

      // R11 stream aborted by a command
      send(8'h20, 8'h00, 8'h00);
      wait_req();
      chk(smp_addr_o == 2'd0, "R11", "new stream address", 32'(smp_addr_o), 32'd0);
      pulse_done();
      send(8'h02, 8'h00, 8'h00);
      reply(3'd2, 8'h07, "R11");
      send(8'h30, 8'h00, 8'h00);
      reply(3'd4, 8'h01, "R11");
      send(8'h01, 8'h00, 8'h00);
      reply(3'd1, 8'hA1, "R11");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule